// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block sits beside a 64-bit receive stream (valid, start, end and empty-byte qualifiers) and produces one status record for every frame it sees. The record is ready in the same cycle as the frame's last beat, so downstream logic can consume the frame and its description together. Bytes are taken in network order, with byte 0 of each beat on data bits 63:56. The empty count on the last beat gives the number of unused bytes at the low end of that beat.

The status word packs the payload length, the total packet length and seven classification flags. The classification covers the destination class, one or two 0x8100 tags, the MAC control type and the pause opcode. A separate error word flags runt, over-length, length-field mismatch, bad FCS and PHY error. The FCS result and the PHY error are per-frame inputs sampled on the end beat. Tag detection and the maximum frame length come from configuration inputs. An overflow input, seen on any beat of a frame, marks that frame's error word as not trustworthy.

Top module: `rx_frame_status`

## Requirements
- R1: `stat_valid` is 1 exactly in the cycle of an accepted end beat. A beat is accepted when `rx_valid` is high and either `rx_sop` is high or a frame is open. `stat_valid` is 0 in every other cycle.
- R2: `stat_word[31:16]` is the frame byte count, including the 4 FCS bytes. `stat_word[15:0]` is the byte count minus (18 + 4 × detected tags), with a floor of 0.
- R3: `stat_word[33]` is set when bytes 12–13 are 0x8100 and `cfg_vlan_en` is 1. `stat_word[32]` is set when, in addition, bytes 16–17 are 0x8100 and `cfg_stack_en` is 1. The length/type field is read right after the last detected tag.
- R4: Exactly one of bits 38 (unicast), 37 (multicast) and 36 (broadcast) is set. Broadcast means destination bytes 0–5 are all 0xFF. Multicast means bit 0 of byte 0 is 1 and the frame is not broadcast. Unicast means bit 0 of byte 0 is 0.
- R5: Bit 34 is set when the length/type field is 0x8808. Bit 35 is set when, in addition, the two following bytes are 0x0001.
- R6: With `cfg_vlan_en` at 0, bits 33:32 are 0 and the length/type field is read at bytes 12–13.
- R7: `stat_err[0]` is set when the byte count is below 64. `stat_err[1]` is set when the byte count exceeds `cfg_max_len` + 4 × detected tags.
- R8: `stat_err[2]` is set when the length/type field is at most 1500 and the payload count is either below it, or above it in a frame longer than 64 bytes.
- R9: `stat_err[3]` copies `eop_fcs_bad` and `stat_err[6]` copies `eop_phy_err`, both taken from the end beat. `stat_err[5:4]` and `stat_word[39]` are 0.
- R10: `stat_err_void` is 1 at the end beat when `rx_ovf` was high on any accepted beat of that frame. It starts at 0 again for the next frame.
- R11: Beats with `rx_valid` low, and beats arriving with no frame open and no start, change no state and raise no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | First beat of a frame |
| rx_eop | input | 1 | Last beat of a frame |
| rx_empty | input | 3 | Unused low-end bytes on the last beat |
| rx_data | input | 64 | Beat data, byte 0 on bits 63:56 |
| rx_ovf | input | 1 | Receive overflow seen on this beat |
| eop_fcs_bad | input | 1 | FCS check failed (end beat) |
| eop_phy_err | input | 1 | PHY reported an error (end beat) |
| cfg_vlan_en | input | 1 | Enable single-tag detection |
| cfg_stack_en | input | 1 | Enable second-tag detection |
| cfg_max_len | input | 16 | Largest untagged frame, in bytes |
| stat_valid | output | 1 | Status record qualifier |
| stat_word | output | 40 | Lengths and class flags |
| stat_err | output | 7 | Error flags |
| stat_err_void | output | 1 | Error word not trustworthy (overflow) |

## Verification
The frame vectors vary one property at a time:
- destination class,
- number of tags against the two detection enables,
- ethertype and opcode,
- lengths placed on each side of the 64-byte minimum and of the maximum with and without a tag,
- length fields equal to, below and above the payload, with and without padding.

Gaps inside a frame, an overflow pulse on a middle beat, and a stray end beat with no frame open show whether state is touched only by accepted beats. Pairing a frame with the enables off against the same frame with them on separates tag detection from the position where the type field is read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam logic [15:0] TPID_TAG    = 16'h8100;
    localparam logic [15:0] CTRL_ETYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OPC   = 16'h0001;
    localparam int          MIN_FRAME   = 64;
    localparam int          MAX_LENFLD  = 1500;
    localparam int          FCS_BYTES   = 4;
    localparam int          TAG_BYTES   = 4;
    localparam int          BASE_HDR    = 14;
    localparam int          HDR_BYTES   = 24;

    // packs into status bits 38:32
    typedef struct packed {
        logic ucast;
        logic mcast;
        logic bcast;
        logic pause;
        logic ctrl;
        logic vlan;
        logic stacked;
    } cls_t;

    // packs into the 7-bit error word
    typedef struct packed {
        logic       phy;
        logic [1:0] spare;
        logic       fcs;
        logic       plen;
        logic       over;
        logic       under;
    } err_t;

endpackage

// File: rtl/rxs_track.sv
module rxs_track #(
    parameter  int BEAT_BYTES = 8,
    parameter  int HDR_BYTES  = 24,
    parameter  int LEN_W      = 16,
    localparam int DATA_W     = BEAT_BYTES * 8,
    localparam int EMPTY_W    = $clog2(BEAT_BYTES),
    localparam int HDR_BEATS  = (HDR_BYTES + BEAT_BYTES - 1) / BEAT_BYTES,
    localparam int BEAT_W     = $clog2(HDR_BEATS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic                          in_eop,
    input  logic [EMPTY_W-1:0]            in_empty,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          in_ovf,
    output logic [HDR_BYTES-1:0][7:0]     hdr_v,
    output logic [LEN_W-1:0]              len_v,
    output logic                          ovf_v,
    output logic                          eop_v
);

    typedef struct packed {
        logic                      in_frame;
        logic                      ovf;
        logic [BEAT_W-1:0]         beat;
        logic [LEN_W-1:0]          cnt;
        logic [HDR_BYTES-1:0][7:0] hdr;
    } trk_t;

    trk_t st_d, st_q;

    logic                      accept;
    logic [HDR_BYTES-1:0][7:0] b_hdr, hdr_cur;
    logic [LEN_W-1:0]          b_cnt, nbytes, cnt_cur;
    logic [BEAT_W-1:0]         b_beat;
    logic                      b_ovf, ovf_cur;
    logic [LEN_W:0]            sum;

    always_comb begin
        st_d    = st_q;
        accept  = in_valid && (in_sop || st_q.in_frame);
        b_hdr   = in_sop ? '0 : st_q.hdr;
        b_cnt   = in_sop ? '0 : st_q.cnt;
        b_beat  = in_sop ? '0 : st_q.beat;
        b_ovf   = in_sop ? 1'b0 : st_q.ovf;
        nbytes  = in_eop ? LEN_W'(BEAT_BYTES) - LEN_W'(in_empty) : LEN_W'(BEAT_BYTES);
        sum     = {1'b0, b_cnt} + {1'b0, nbytes};
        cnt_cur = sum[LEN_W] ? '1 : sum[LEN_W-1:0];
        ovf_cur = b_ovf | in_ovf;
        hdr_cur = b_hdr;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (accept && (i / BEAT_BYTES) == int'(b_beat)
                && LEN_W'(i % BEAT_BYTES) < nbytes) begin
                hdr_cur[i] = in_data[DATA_W-1-8*(i % BEAT_BYTES) -: 8];
            end
        end
        if (accept) begin
            st_d.in_frame = !in_eop;
            st_d.ovf      = ovf_cur;
            st_d.cnt      = cnt_cur;
            st_d.hdr      = hdr_cur;
            st_d.beat     = (int'(b_beat) < HDR_BEATS) ? b_beat + 1'b1 : b_beat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_v = hdr_cur;
    assign len_v = cnt_cur;
    assign ovf_v = ovf_cur;
    assign eop_v = accept && in_eop;

    // R11: a beat that is not accepted leaves the stored state unchanged
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
    import rxs_pkg::*;
#(
    parameter int HB = HDR_BYTES
) (
    input  logic [HB-1:0][7:0] hdr,
    input  logic               vlan_en,
    input  logic               stack_en,
    output cls_t               cls,
    output logic [1:0]         ntags,
    output logic [15:0]        len_type
);

    logic        tag1, tag2, bc;
    logic [15:0] opc;

    always_comb begin
        tag1  = vlan_en && ({hdr[12], hdr[13]} == TPID_TAG);
        tag2  = tag1 && stack_en && ({hdr[16], hdr[17]} == TPID_TAG);
        ntags = {1'b0, tag1} + {1'b0, tag2};
        if (tag2) begin
            len_type = {hdr[20], hdr[21]};
            opc      = {hdr[22], hdr[23]};
        end else if (tag1) begin
            len_type = {hdr[16], hdr[17]};
            opc      = {hdr[18], hdr[19]};
        end else begin
            len_type = {hdr[12], hdr[13]};
            opc      = {hdr[14], hdr[15]};
        end
        bc          = &{hdr[0], hdr[1], hdr[2], hdr[3], hdr[4], hdr[5]};
        cls.ucast   = !hdr[0][0];
        cls.mcast   = hdr[0][0] && !bc;
        cls.bcast   = bc;
        cls.ctrl    = (len_type == CTRL_ETYPE);
        cls.pause   = cls.ctrl && (opc == PAUSE_OPC);
        cls.vlan    = tag1;
        cls.stacked = tag2;
    end

endmodule

// File: rtl/rxs_errchk.sv
module rxs_errchk
    import rxs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       ntags,
    input  logic [15:0]      len_type,
    input  logic [15:0]      max_len,
    input  logic             fcs_bad,
    input  logic             phy_err,
    output err_t             err,
    output logic [LEN_W-1:0] payload
);

    logic [LEN_W:0]   limit;
    logic [LEN_W-1:0] ovh, lt;

    always_comb begin
        limit   = (LEN_W+1)'(max_len) + (LEN_W+1)'(int'(ntags) * TAG_BYTES);
        ovh     = LEN_W'(BASE_HDR + FCS_BYTES + int'(ntags) * TAG_BYTES);
        payload = (len > ovh) ? len - ovh : '0;
        lt      = LEN_W'(len_type);
        err.under = len < LEN_W'(MIN_FRAME);
        err.over  = {1'b0, len} > limit;
        err.plen  = (len_type <= 16'(MAX_LENFLD))
                    && ((payload < lt) || (payload > lt && len > LEN_W'(MIN_FRAME)));
        err.fcs   = fcs_bad;
        err.spare = 2'b00;
        err.phy   = phy_err;
    end

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rxs_pkg::*;
#(
    parameter  int BEAT_BYTES = 8,
    parameter  int LEN_W      = 16,
    localparam int DATA_W     = BEAT_BYTES * 8,
    localparam int EMPTY_W    = $clog2(BEAT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sop,
    input  logic               rx_eop,
    input  logic [EMPTY_W-1:0] rx_empty,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_ovf,
    input  logic               eop_fcs_bad,
    input  logic               eop_phy_err,
    input  logic               cfg_vlan_en,
    input  logic               cfg_stack_en,
    input  logic [15:0]        cfg_max_len,
    output logic               stat_valid,
    output logic [39:0]        stat_word,
    output logic [6:0]         stat_err,
    output logic               stat_err_void
);

    logic [HDR_BYTES-1:0][7:0] hdr_v;
    logic [LEN_W-1:0]          len_v, payload;
    logic                      ovf_v, eop_v;
    cls_t                      cls;
    err_t                      err;
    logic [1:0]                ntags;
    logic [15:0]               len_type;

    rxs_track #(.BEAT_BYTES(BEAT_BYTES), .HDR_BYTES(HDR_BYTES), .LEN_W(LEN_W)) u_track (
        .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_sop(rx_sop),
        .in_eop(rx_eop), .in_empty(rx_empty), .in_data(rx_data), .in_ovf(rx_ovf),
        .hdr_v(hdr_v), .len_v(len_v), .ovf_v(ovf_v), .eop_v(eop_v)
    );

    rxs_classify #(.HB(HDR_BYTES)) u_cls (
        .hdr(hdr_v), .vlan_en(cfg_vlan_en), .stack_en(cfg_stack_en),
        .cls(cls), .ntags(ntags), .len_type(len_type)
    );

    rxs_errchk #(.LEN_W(LEN_W)) u_err (
        .len(len_v), .ntags(ntags), .len_type(len_type), .max_len(cfg_max_len),
        .fcs_bad(eop_fcs_bad), .phy_err(eop_phy_err), .err(err), .payload(payload)
    );

    assign stat_valid    = eop_v;
    assign stat_word     = {1'b0, cls, 16'(len_v), 16'(payload)};
    assign stat_err      = err;
    assign stat_err_void = eop_v && ovf_v;

    assert_valid_on_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (rx_valid && rx_eop));
    assert_one_cast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> ($countones(stat_word[38:36]) == 1));
    assert_stack_needs_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_word[32]) |-> stat_word[33]);
    assert_pause_is_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_word[35]) |-> stat_word[34]);
    assert_tag_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !cfg_vlan_en) |-> (stat_word[33:32] == 2'b00));
    assert_runt_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_word[31:16] < 16'd64) |-> stat_err[0]);
    assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (!stat_word[39] && stat_err[5:4] == 2'b00));
    assert_void_on_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && rx_ovf) |-> stat_err_void);

endmodule

// File: tb/tb_rx_frame_status.sv
`timescale 1ns/1ps
module tb_rx_frame_status;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sop, rx_eop, rx_ovf, eop_fcs_bad, eop_phy_err;
    logic [2:0]  rx_empty;
    logic [63:0] rx_data;
    logic        cfg_vlan_en, cfg_stack_en;
    logic [15:0] cfg_max_len;
    logic        stat_valid, stat_err_void;
    logic [39:0] stat_word;
    logic [6:0]  stat_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rx_frame_status dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_empty(rx_empty), .rx_data(rx_data), .rx_ovf(rx_ovf),
        .eop_fcs_bad(eop_fcs_bad), .eop_phy_err(eop_phy_err),
        .cfg_vlan_en(cfg_vlan_en), .cfg_stack_en(cfg_stack_en),
        .cfg_max_len(cfg_max_len), .stat_valid(stat_valid), .stat_word(stat_word),
        .stat_err(stat_err), .stat_err_void(stat_err_void)
    );

    // cls order: {ucast,mcast,bcast,pause,ctrl,vlan,stacked} = status bits 38:32
    typedef struct packed {
        logic [15:0] len;
        logic [1:0]  dk;    // 0 unicast, 1 multicast, 2 broadcast
        logic [1:0]  tags;
        logic [15:0] lt;
        logic [15:0] op;
        logic        ven;
        logic        sen;
        logic [15:0] maxl;
        logic        crc;
        logic        phy;
        logic        ovf;
        logic        gap;
        logic [6:0]  cls;
        logic [15:0] pay;
        logic [6:0]  err;
        logic        evoid;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'd64,   2'd0, 2'd0, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd46,   7'b0000000, 1'b0},
        '{16'd100,  2'd2, 2'd1, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0010010, 16'd78,   7'b0000000, 1'b0},
        '{16'd120,  2'd1, 2'd2, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0100011, 16'd94,   7'b0000000, 1'b0},
        '{16'd120,  2'd1, 2'd2, 16'h0800, 16'h0000, 1'b1, 1'b0, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0100010, 16'd98,   7'b0000000, 1'b0},
        '{16'd64,   2'd0, 2'd1, 16'h0800, 16'h0000, 1'b0, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd46,   7'b0000000, 1'b0},
        '{16'd64,   2'd1, 2'd0, 16'h8808, 16'h0001, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0101100, 16'd46,   7'b0000000, 1'b0},
        '{16'd64,   2'd0, 2'd0, 16'h8808, 16'h0002, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000100, 16'd46,   7'b0000000, 1'b0},
        '{16'd60,   2'd0, 2'd0, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd42,   7'b0000001, 1'b0},
        '{16'd1519, 2'd0, 2'd0, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd1501, 7'b0000010, 1'b0},
        '{16'd1522, 2'd0, 2'd1, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000010, 16'd1500, 7'b0000000, 1'b0},
        '{16'd1523, 2'd0, 2'd1, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000010, 16'd1501, 7'b0000010, 1'b0},
        '{16'd100,  2'd0, 2'd0, 16'd82,   16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd82,   7'b0000000, 1'b0},
        '{16'd100,  2'd0, 2'd0, 16'd80,   16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd82,   7'b0000100, 1'b0},
        '{16'd64,   2'd0, 2'd0, 16'd20,   16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd46,   7'b0000000, 1'b0},
        '{16'd64,   2'd0, 2'd0, 16'd50,   16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd46,   7'b0000100, 1'b0},
        '{16'd100,  2'd0, 2'd0, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b1, 1'b1, 1'b0, 1'b1, 7'b1000000, 16'd82,   7'b1001000, 1'b0},
        '{16'd100,  2'd0, 2'd0, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1000000, 16'd82,   7'b0000000, 1'b1},
        '{16'd65,   2'd0, 2'd0, 16'd30,   16'h0000, 1'b1, 1'b1, 16'd1518, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000, 16'd47,   7'b0000100, 1'b0}
    };

    logic [7:0] fb [0:2047];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_empty = '0;
        rx_data = '0; rx_ovf = 1'b0; eop_fcs_bad = 1'b0; eop_phy_err = 1'b0;
    endtask

    task automatic build(input vec_t v);
        int p;
        for (int i = 0; i < int'(v.len); i++) fb[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 6; i++) begin
            case (v.dk)
                2'd0:    fb[i] = (i == 0) ? 8'h00 : 8'(8'haa + 8'(i * 17));
                2'd1:    fb[i] = (i == 0) ? 8'h01 : ((i == 1) ? 8'h80 : ((i == 2) ? 8'hc2 : ((i == 5) ? 8'h01 : 8'h00)));
                default: fb[i] = 8'hff;
            endcase
            fb[6+i] = 8'(i * 8'h11);
        end
        p = 12;
        for (int t = 0; t < int'(v.tags); t++) begin
            fb[p] = 8'h81; fb[p+1] = 8'h00; fb[p+2] = 8'h00; fb[p+3] = 8'h05;
            p += 4;
        end
        fb[p]   = v.lt[15:8]; fb[p+1] = v.lt[7:0];
        fb[p+2] = v.op[15:8]; fb[p+3] = v.op[7:0];
    endtask

    task automatic send(input vec_t v, input int idx);
        int nb;
        int early;
        nb    = (int'(v.len) + 7) / 8;
        early = 0;
        build(v);
        cfg_vlan_en = v.ven; cfg_stack_en = v.sen; cfg_max_len = v.maxl;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sop   = (b == 0);
            rx_eop   = (b == nb - 1);
            rx_empty = rx_eop ? 3'(nb * 8 - int'(v.len)) : 3'd0;
            for (int k = 0; k < 8; k++)
                rx_data[63-8*k -: 8] = (b * 8 + k < int'(v.len)) ? fb[b*8+k] : 8'h00;
            rx_ovf      = v.ovf && (b == 1);
            eop_fcs_bad = rx_eop && v.crc;
            eop_phy_err = rx_eop && v.phy;
            #1;
            if (rx_eop) begin
                $display("vector %0d", idx);
                check("R1 valid on end beat", 64'(stat_valid), 64'd1);
                check("R2 packet length", 64'(stat_word[31:16]), 64'(v.len));
                check("R2 payload length", 64'(stat_word[15:0]), 64'(v.pay));
                check("R3 R4 R5 R6 class bits", 64'(stat_word[38:32]), 64'(v.cls));
                check("R7 R8 R9 error word", 64'(stat_err), 64'(v.err));
                check("R9 reserved status bit", 64'(stat_word[39]), 64'd0);
                check("R10 void flag", 64'(stat_err_void), 64'(v.evoid));
            end else if (stat_valid) begin
                early++;
            end
            if (v.gap && b == 0) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b1;
                #1;
                check("R11 gap beat raises no status", 64'(stat_valid), 64'd0);
            end
        end
        check("R1 no status before end beat", 64'(early), 64'd0);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        cfg_vlan_en = 1'b1; cfg_stack_en = 1'b1; cfg_max_len = 16'd1518;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset: no status", 64'(stat_valid), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) send(VECS[i], i);

        // R11: end beat with no frame open is ignored
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b0; rx_eop = 1'b1; rx_data = '1;
        #1;
        check("R11 stray end beat ignored", 64'(stat_valid), 64'd0);
        @(negedge clk);
        idle();

        // R10: overflow does not carry into the next frame
        send(VECS[16], 16);
        send(VECS[0], 0);

        // reset in the middle of a frame closes it: a following body beat is ignored
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = 64'h00aabbccddee0011;
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rx_valid = 1'b1; rx_eop = 1'b1;
        #1;
        check("R11 beat after reset without start ignored", 64'(stat_valid), 64'd0);
        @(negedge clk);
        idle();
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule